// File: doc/BRIEF.md
# Command-Mode Baud Rate Controller

This block chooses the bit period for a UART-side serial link and produces a bit-clock strobe at sixteen strobes per bit. It has two ways to choose the bit period. Three strap pins can select one of five fixed divisors of the system clock. The all-ones strap code hands the choice to the host controller, which changes the rate in band over its own serial line.

With the all-ones strap active, a low level on the mode-select input puts the block in command mode. In command mode each byte the host sends is looped back to the host bit by bit, with a lag of about half a bit. The path to the infrared encoder is held idle and the decoder output is not used. The block also parses the bytes it echoes. A rate byte is remembered as pending. A change byte then makes the pending rate the active one, at the exact clock where the echoed stop bit of the change byte ends. When the mode-select input is high, the host lines connect straight to the encoder and decoder.

Top module: `baud_cmd_ctrl`

## Requirements
- R1: In strap mode, `bit_div` follows `rate_pins`: code 0 gives 768, code 1 gives 384, code 2 gives 192, code 3 gives 128 and code 4 gives 64. Codes 5 and 6 also give 768.
- R2: With `rate_pins` = 3'b111 the block is in software mode. After reset the software divisor is 768.
- R3: `bit_tick` pulses once every `bit_div`/16 clocks, so there are 16 pulses per bit time.
- R4: `rate_pins` is latched only while the byte receiver is idle. A strap change made during a frame has no effect on `bit_div` until that frame's stop bit has been sampled.
- R5: Command mode is software mode with `cmd_sel_n` low (after two sync flops). In command mode `enc_txd` is held at 1 and `host_rxd` carries the echo, so `dec_rxd` has no effect on it. In every other case `enc_txd` follows `host_txd` and `host_rxd` follows `dec_rxd`.
- R6: In command mode each received bit (start, 8 data bits LSB first, stop) appears on `host_rxd`. The echo lags the matching `host_txd` edge by exactly `bit_div`/2 + 3 clocks, which is less than one bit time.
- R7: A rate byte is stored as pending and leaves `bit_div` unchanged. The rate bytes are 8'h87→768, 8'h8B→384, 8'h85→192, 8'h83→128 and 8'h81→64.
- R8: Byte 8'h11 with a rate pending makes the pending divisor active. The change lands exactly `bit_div` clocks after the stop bit is sampled, which is `bit_div`/2 + 3 + `bit_div` clocks after the host starts the stop bit.
- R9: Any other byte leaves the divisor and the pending rate untouched. An 8'h11 received while nothing has been pending since reset changes nothing.
- R10: After a change, bytes are received and echoed at the new rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_pins | input | 3 | Rate strap code; 3'b111 selects software mode |
| cmd_sel_n | input | 1 | Low requests command mode (used in software mode only) |
| host_txd | input | 1 | Serial data from the host UART |
| host_rxd | output | 1 | Serial data to the host UART |
| enc_txd | output | 1 | Serial data toward the infrared encoder |
| dec_rxd | input | 1 | Serial data from the infrared decoder |
| bit_div | output | 10 | Active divisor, in clocks per bit |
| bit_tick | output | 1 | Bit-clock strobe, 16 per bit |

## Verification
The echo is driven with bytes whose bit patterns differ, at both the slowest and the fastest rate. Each echoed bit is checked just before the next host bit starts. The start-bit edge is pinned to one exact clock, which separates a correct half-bit lag from a lag that is off by one. Three byte orders test the command parser:
- A rate byte, then a reserved byte, then the change byte. This checks that the change commits on the exact clock.
- A lone change byte after reset. This separates a pending register that resets to "none" from one that does not.
- A reserved byte placed between a rate byte and the change byte. This checks that reserved codes leave the pending rate alone.

A strap change in the middle of a frame tells a latch that waits for idle apart from a transparent one.

// File: rtl/baud_cmd_pkg.sv
package baud_cmd_pkg;
  localparam int DIV_W      = 10;
  localparam int PIN_W      = 3;
  localparam int BYTE_W     = 8;
  localparam int TICK_SHIFT = 4;

  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [PIN_W-1:0]  pin_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam pin_t  SW_CODE  = '1;
  localparam byte_t CHG_BYTE = 8'h11;
  localparam div_t  DEF_DIV  = div_t'(768);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_COMMIT} rx_state_t;

  function automatic div_t pin_div(pin_t c);
    case (c)
      3'd1:    return div_t'(384);
      3'd2:    return div_t'(192);
      3'd3:    return div_t'(128);
      3'd4:    return div_t'(64);
      default: return DEF_DIV;
    endcase
  endfunction

  function automatic logic is_rate_byte(byte_t b);
    return (b == 8'h87) || (b == 8'h8B) || (b == 8'h85) || (b == 8'h83) || (b == 8'h81);
  endfunction

  function automatic div_t byte_div(byte_t b);
    case (b)
      8'h8B:   return div_t'(384);
      8'h85:   return div_t'(192);
      8'h83:   return div_t'(128);
      8'h81:   return div_t'(64);
      default: return DEF_DIV;
    endcase
  endfunction
endpackage

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import baud_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  div_t div_i,
  output logic tick_o
);
  div_t cnt_q;
  div_t limit_w;

  assign limit_w = (div_i >> TICK_SHIFT) - div_t'(1);
  assign tick_o  = (cnt_q >= limit_w);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + div_t'(1);
  end

  p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/cmd_echo_rx.sv
module cmd_echo_rx
  import baud_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  rxd_i,
  input  div_t  div_i,
  input  logic  pend_ok_i,
  output logic  echo_o,
  output logic  idle_o,
  output logic  byte_done_o,
  output byte_t byte_o,
  output logic  commit_o
);
  rx_state_t st_q;
  div_t      cnt_q;
  logic [2:0] bitn_q;
  byte_t     shreg_q;
  logic      echo_q;

  logic samp_w, abort_w, cnt_zero_w;

  assign cnt_zero_w  = (cnt_q == '0);
  assign abort_w     = !en_i && (st_q != RX_IDLE);
  assign samp_w      = en_i && cnt_zero_w &&
                       ((st_q == RX_START) || (st_q == RX_DATA) || (st_q == RX_STOP));
  assign byte_done_o = samp_w && (st_q == RX_STOP) && rxd_i;
  assign commit_o    = en_i && cnt_zero_w && (st_q == RX_COMMIT);
  assign idle_o      = (st_q == RX_IDLE);
  assign echo_o      = echo_q;
  assign byte_o      = shreg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      echo_q  <= 1'b1;
    end else if (abort_w) begin
      st_q   <= RX_IDLE;
      echo_q <= 1'b1;
    end else begin
      if (!cnt_zero_w) cnt_q <= cnt_q - div_t'(1);
      case (st_q)
        RX_IDLE: if (en_i && !rxd_i) begin
          st_q  <= RX_START;
          cnt_q <= (div_i >> 1) - div_t'(1);
        end
        RX_START: if (samp_w) begin
          echo_q <= rxd_i;
          if (rxd_i) st_q <= RX_IDLE;
          else begin
            st_q   <= RX_DATA;
            bitn_q <= '0;
            cnt_q  <= div_i - div_t'(1);
          end
        end
        RX_DATA: if (samp_w) begin
          echo_q  <= rxd_i;
          shreg_q <= {rxd_i, shreg_q[BYTE_W-1:1]};
          bitn_q  <= bitn_q + 3'd1;
          cnt_q   <= div_i - div_t'(1);
          if (bitn_q == 3'd7) st_q <= RX_STOP;
        end
        RX_STOP: if (samp_w) begin
          echo_q <= rxd_i;
          if (rxd_i && (shreg_q == CHG_BYTE) && pend_ok_i) begin
            st_q  <= RX_COMMIT;
            cnt_q <= div_i - div_t'(1);
          end else begin
            st_q <= RX_IDLE;
          end
        end
        RX_COMMIT: if (commit_o) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  p_echo_on_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(echo_q) |-> $past(samp_w || abort_w));
  p_idle_echo_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort_w) |-> echo_q);
endmodule

// File: rtl/rate_keeper.sv
module rate_keeper
  import baud_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pin_t  pins_i,
  input  logic  idle_i,
  input  logic  byte_done_i,
  input  byte_t byte_i,
  input  logic  commit_i,
  output logic  sw_mode_o,
  output logic  pend_ok_o,
  output div_t  div_o
);
  pin_t pin_q;
  div_t sw_div_q;
  div_t pend_div_q;
  logic pend_vld_q;
  logic rate_hit_w;

  assign rate_hit_w = byte_done_i && is_rate_byte(byte_i);
  assign sw_mode_o  = (pin_q == SW_CODE);
  assign pend_ok_o  = pend_vld_q;
  assign div_o      = sw_mode_o ? sw_div_q : pin_div(pin_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q      <= '0;
      sw_div_q   <= DEF_DIV;
      pend_div_q <= DEF_DIV;
      pend_vld_q <= 1'b0;
    end else begin
      if (idle_i) pin_q <= pins_i;
      if (rate_hit_w) begin
        pend_div_q <= byte_div(byte_i);
        pend_vld_q <= 1'b1;
      end
      if (commit_i) sw_div_q <= pend_div_q;
    end
  end

  p_div_held_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!idle_i) && $past(!commit_i)) |-> $stable(div_o));
  p_commit_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> pend_vld_q);
  p_reserved_keeps_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && !is_rate_byte(byte_i)) |=> ($stable(pend_div_q) && $stable(pend_vld_q)));
endmodule

// File: rtl/baud_cmd_ctrl.sv
module baud_cmd_ctrl
  import baud_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  rate_pins,
  input  logic        cmd_sel_n,
  input  logic        host_txd,
  output logic        host_rxd,
  output logic        enc_txd,
  input  logic        dec_rxd,
  output logic [9:0]  bit_div,
  output logic        bit_tick
);
  logic [1:0] txd_sync_q, sel_sync_q;
  logic  sw_mode_w, cmd_mode_w, pend_ok_w;
  logic  echo_w, idle_w, byte_done_w, commit_w;
  byte_t byte_w;
  div_t  div_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd_sync_q <= '1;
      sel_sync_q <= '1;
    end else begin
      txd_sync_q <= {txd_sync_q[0], host_txd};
      sel_sync_q <= {sel_sync_q[0], cmd_sel_n};
    end
  end

  assign cmd_mode_w = sw_mode_w && !sel_sync_q[1];
  assign enc_txd    = cmd_mode_w ? 1'b1 : host_txd;
  assign host_rxd   = cmd_mode_w ? echo_w : dec_rxd;
  assign bit_div    = div_w;

  cmd_echo_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(cmd_mode_w), .rxd_i(txd_sync_q[1]),
    .div_i(div_w), .pend_ok_i(pend_ok_w), .echo_o(echo_w), .idle_o(idle_w),
    .byte_done_o(byte_done_w), .byte_o(byte_w), .commit_o(commit_w)
  );

  rate_keeper u_rate (
    .clk(clk), .rst_n(rst_n), .pins_i(rate_pins), .idle_i(idle_w),
    .byte_done_i(byte_done_w), .byte_i(byte_w), .commit_i(commit_w),
    .sw_mode_o(sw_mode_w), .pend_ok_o(pend_ok_w), .div_o(div_w)
  );

  bitclk_gen u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(div_w), .tick_o(bit_tick)
  );
endmodule

// File: tb/baud_cmd_ctrl_test.sv
module baud_cmd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_pins;
  logic       cmd_sel_n, host_txd, dec_rxd;
  logic       host_rxd, enc_txd, bit_tick;
  logic [9:0] bit_div;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  baud_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rate_pins(rate_pins), .cmd_sel_n(cmd_sel_n),
    .host_txd(host_txd), .host_rxd(host_rxd), .enc_txd(enc_txd),
    .dec_rxd(dec_rxd), .bit_div(bit_div), .bit_tick(bit_tick)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int strap_div(input int code);
    case (code)
      1: return 768 / 2;
      2: return 768 / 4;
      3: return 768 / 6;
      4: return 768 / 12;
      default: return 768;
    endcase
  endfunction

  task automatic do_reset;
    rst_n = 1'b0; host_txd = 1'b1; dec_rxd = 1'b1; cmd_sel_n = 1'b1;
    step(4);
    rst_n = 1'b1;
    step(3);
  endtask

  // one host frame; checks the echo of every bit (R6) and the idle encoder (R5)
  task automatic send_byte(input logic [7:0] b, input int div, input int chg_bit,
                           input logic [2:0] chg_pins);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      host_txd = v;
      if (i == chg_bit) rate_pins = chg_pins;
      if (i == 0) begin
        step(div / 2 + 2);
        chk_eq("R6 echo not yet fallen", host_rxd, 1);
        step(1);
        chk_eq("R6 echo start edge", host_rxd, 0);
        step(div - 2 - (div / 2 + 3));
      end else begin
        step(div - 2);
      end
      chk_eq("R6 echoed bit", host_rxd, v);
      chk_eq("R5 encoder idle in command mode", enc_txd, 1);
      if (i < 9) chk_eq("R4 divisor held during frame", bit_div, div);
      step(2);
    end
  endtask

  task automatic commit_check(input string req, input int old_div, input int new_div);
    chk_eq(req, bit_div, old_div);
    step(old_div / 2 + 2);
    chk_eq(req, bit_div, old_div);
    step(1);
    chk_eq(req, bit_div, new_div);
  endtask

  task automatic t_reset;
    rate_pins = 3'b000;
    do_reset();
    chk_eq("R1 reset strap divisor", bit_div, 768);
    chk_eq("R5 reset host line", host_rxd, 1);
  endtask

  task automatic t_straps;
    for (int c = 0; c < 7; c++) begin
      rate_pins = 3'(c);
      step(3);
      chk_eq("R1 strap divisor", bit_div, strap_div(c));
    end
    rate_pins = 3'b111;
    step(3);
    chk_eq("R2 software default", bit_div, 768);
  endtask

  task automatic t_ticks;
    int n;
    n = 0;
    rate_pins = 3'b100;
    step(4);
    for (int k = 0; k < 640; k++) begin
      step(1);
      if (bit_tick) n++;
    end
    chk_eq("R3 ticks in ten bits", n, 160);
  endtask

  task automatic t_data_mode;
    rate_pins = 3'b111; cmd_sel_n = 1'b1;
    step(4);
    host_txd = 1'b0; step(1);
    chk_eq("R5 data mode encoder path", enc_txd, 0);
    host_txd = 1'b1; dec_rxd = 1'b0; step(1);
    chk_eq("R5 data mode decoder path", host_rxd, 0);
    dec_rxd = 1'b1;
    cmd_sel_n = 1'b0; step(4);
    dec_rxd = 1'b0; step(1);
    chk_eq("R5 decoder ignored in command mode", host_rxd, 1);
    dec_rxd = 1'b1; step(2);
  endtask

  task automatic t_change_rate;
    send_byte(8'h81, 768, -1, 3'b111);
    step(768);
    chk_eq("R7 rate byte only pending", bit_div, 768);
    send_byte(8'h55, 768, -1, 3'b111);
    step(768);
    chk_eq("R9 reserved byte no change", bit_div, 768);
    send_byte(8'h11, 768, -1, 3'b111);
    commit_check("R8 commit at echoed stop end", 768, 64);
    step(64);
    send_byte(8'hA5, 64, -1, 3'b111);
    step(64);
    chk_eq("R10 new rate kept", bit_div, 64);
    cmd_sel_n = 1'b1; step(4);
    dec_rxd = 1'b0; step(1);
    chk_eq("R5 back to data mode", host_rxd, 0);
    dec_rxd = 1'b1; step(1);
  endtask

  task automatic t_no_pending;
    rate_pins = 3'b111;
    do_reset();
    cmd_sel_n = 1'b0; step(4);
    send_byte(8'h11, 768, -1, 3'b111);
    commit_check("R9 change with nothing pending", 768, 768);
    step(768);
    send_byte(8'h8B, 768, -1, 3'b111);
    step(768);
    send_byte(8'h3C, 768, -1, 3'b111);
    step(768);
    send_byte(8'h11, 768, -1, 3'b111);
    commit_check("R9 pending survives reserved byte", 768, 384);
    step(384);
  endtask

  task automatic t_strap_latch;
    send_byte(8'h6E, 384, 3, 3'b100);
    step(384);
    chk_eq("R4 strap applied after frame", bit_div, 64);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    t_reset();
    t_straps();
    t_ticks();
    t_data_mode();
    t_change_rate();
    t_no_pending();
    t_strap_latch();
    summary();
  end
endmodule